// File: doc/BRIEF.md
# Two-Tap Predictive ADPCM Block Decoder

This block turns one compressed audio block of 16 bytes into 28 signed 16-bit PCM samples. The first byte of a block is a header carrying a right-shift amount and a predictor selector. The second byte carries flags that this block does not interpret. The remaining 14 bytes pack the 28 four-bit codes. Each code is placed at the top of a 16-bit word and shifted right arithmetically. A two-tap linear prediction built from the two previous outputs is then added, and the result is saturated to 16 bits.

A block enters either as one 128-bit word with a one-cycle strobe, or as sixteen bytes on a byte port, which may have idle cycles between them. Once a block is accepted, the decoder emits one sample per clock for 28 clocks and pulses a done flag with the last one. The two prediction history values hold the unsaturated sums. They survive from one block to the next, so consecutive blocks of one stream decode seamlessly. A reset sets both history values to zero.

Top module: `adpcm_block_decoder`

## Requirements
- R1: When idle, a high `blk_start` at a rising edge S accepts `blk_word`, with block byte k at bits 8k+7:8k. Sample i is then shown with `smp_valid` high and `smp_index` equal to i during the cycle after edge S+1+i, for i from 0 to 27.
- R2: When idle and `blk_start` is low, every cycle with `byte_valid` high takes `byte_data` as the next block byte, starting at byte 0. Idle gaps between bytes are allowed. The edge that takes byte 15 acts as edge S of R1.
- R3: The shift amount is header bits 3:0 and the predictor selector is header bits 6:4. Header bit 7 and the whole flag byte (byte 1) have no effect on the samples.
- R4: Sample i comes from block byte 2 + i/2: the low nibble when i is even, the high nibble when i is odd.
- R5: A sample equals base + (h1·P + h2·N + 32)/64, where base is the nibble placed in bits 15:12 of a signed 16-bit word and shifted right arithmetically by the shift amount, and h1 is the newer history value. (P,N) for selector 0..4 is (0,0), (60,0), (115,−52), (98,−55), (122,−60). Selectors 5, 6 and 7 decode as selector 0.
- R6: The division by 64 truncates toward zero, so −28/64 gives 0.
- R7: The output is saturated to −32768..32767. The history takes the unsaturated sum.
- R8: The history carries over from one block into the next. Reset sets both history values to zero.
- R9: `busy` is high from edge S through the edge that shows sample 27. `blk_done` is high only together with sample 27. `blk_start` and `byte_valid` have no effect while `busy` is high.
- R10: When idle, `blk_start` takes priority over `byte_valid` in the same cycle. That byte is not taken.
- R11: After reset, `busy`, `smp_valid` and `blk_done` are low and the byte count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Accept `blk_word` as a block |
| blk_word | input | 128 | Whole block, byte k at bits 8k+7:8k |
| byte_valid | input | 1 | `byte_data` holds the next block byte |
| byte_data | input | 8 | Block byte for the byte-stream path |
| smp_valid | output | 1 | Sample output valid |
| smp_data | output | OUT_W (16) | Saturated signed sample |
| smp_index | output | 5 | Position of the sample in its block |
| blk_done | output | 1 | High with the last sample of a block |
| busy | output | 1 | Decoding in progress |

## Verification
Both input paths have the same latency. The edge that accepts the block (the strobe, or byte 15) is edge S, and sample i is registered at edge S+1+i. The bench therefore waits for edge S, then checks `busy` on the falling edge that follows. For each sample it waits one more rising edge and compares the sample, its index and the done flag on the falling edge after that edge. After sample 27 the bench checks the same falling edge for `busy` low. A bench-side model of the history predicts every value. Inputs applied while the decoder is busy are judged by whether the cycle after the block stays quiet, and by whether a following byte-fed block still decodes correctly.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
    localparam int BLK_BYTES   = 16;
    localparam int BYTE_W      = 8;
    localparam int BLK_W       = BLK_BYTES * BYTE_W;
    localparam int HDR_BYTES   = 2;
    localparam int DATA_W      = BLK_W - HDR_BYTES * BYTE_W;
    localparam int NIB_W       = 4;
    localparam int SMP_PER_BLK = DATA_W / NIB_W;
    localparam int IDX_W       = $clog2(SMP_PER_BLK);
    localparam int SHIFT_W     = 4;
    localparam int SEL_W       = 3;
    localparam int COEF_W      = 8;
    localparam int RND         = 32;
    localparam int DIV_SH      = 6;

    // Newest-history weight; unknown selectors fall back to zero.
    function automatic logic signed [COEF_W-1:0] coef_near(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd1:    return 8'sd60;
            3'd2:    return 8'sd115;
            3'd3:    return 8'sd98;
            3'd4:    return 8'sd122;
            default: return 8'sd0;
        endcase
    endfunction

    // Older-history weight.
    function automatic logic signed [COEF_W-1:0] coef_far(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd2:    return -8'sd52;
            3'd3:    return -8'sd55;
            3'd4:    return -8'sd60;
            default: return 8'sd0;
        endcase
    endfunction
endpackage

// File: rtl/adpcm_byte_gather.sv
module adpcm_byte_gather
    import adpcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic             full_o,
    output logic [BLK_W-1:0] word_o
);
    localparam int CNT_W = $clog2(BLK_BYTES);
    localparam int BUF_W = (BLK_BYTES - 1) * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BUF_W-1:0] bytes;
    } gath_t;

    gath_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        full_o = 1'b0;
        if (take) begin
            if (st_q.cnt == CNT_W'(BLK_BYTES - 1)) begin
                full_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.bytes[st_q.cnt*BYTE_W +: BYTE_W] = byte_in;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    assign word_o = {byte_in, st_q.bytes};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adpcm_nibble_pick.sv
module adpcm_nibble_pick
    import adpcm_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [NIB_W-1:0]  nib_o
);
    logic [NIB_W-1:0] nib_arr [SMP_PER_BLK];

    // Low nibble of each byte first: code i sits at bit offset NIB_W*i.
    for (genvar g = 0; g < SMP_PER_BLK; g++) begin : g_nib
        assign nib_arr[g] = data_i[g*NIB_W +: NIB_W];
    end

    always_comb begin
        nib_o = '0;
        if (idx_i < IDX_W'(SMP_PER_BLK)) nib_o = nib_arr[idx_i];
    end
endmodule

// File: rtl/adpcm_predictor.sv
module adpcm_predictor
    import adpcm_pkg::*;
#(
    parameter int HIST_W = 32,
    parameter int OUT_W  = 16
) (
    input  logic [NIB_W-1:0]         nib_i,
    input  logic [SHIFT_W-1:0]       shift_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic signed [HIST_W-1:0] h1_i,
    input  logic signed [HIST_W-1:0] h2_i,
    output logic signed [HIST_W-1:0] sum_o,
    output logic signed [OUT_W-1:0]  smp_o
);
    localparam int ACC_W  = HIST_W + COEF_W + 2;
    localparam int BASE_W = 16;
    localparam logic signed [HIST_W-1:0] SMAX = HIST_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [HIST_W-1:0] SMIN = -SMAX - HIST_W'(1);

    logic signed [BASE_W-1:0] base;
    logic signed [COEF_W-1:0] cn, cf;
    logic signed [ACC_W-1:0]  h1x, h2x, cnx, cfx, basex, acc, quo, sumx;

    always_comb begin
        base  = $signed({nib_i, {(BASE_W-NIB_W){1'b0}}}) >>> shift_i;
        cn    = coef_near(sel_i);
        cf    = coef_far(sel_i);
        h1x   = {{(ACC_W-HIST_W){h1_i[HIST_W-1]}}, h1_i};
        h2x   = {{(ACC_W-HIST_W){h2_i[HIST_W-1]}}, h2_i};
        cnx   = {{(ACC_W-COEF_W){cn[COEF_W-1]}}, cn};
        cfx   = {{(ACC_W-COEF_W){cf[COEF_W-1]}}, cf};
        basex = {{(ACC_W-BASE_W){base[BASE_W-1]}}, base};
        acc   = h1x * cnx + h2x * cfx + ACC_W'(RND);
        // Bias negatives so the shift truncates toward zero.
        if (acc[ACC_W-1]) quo = (acc + ACC_W'((1 << DIV_SH) - 1)) >>> DIV_SH;
        else              quo = acc >>> DIV_SH;
        sumx  = basex + quo;
        sum_o = sumx[HIST_W-1:0];
        if (sum_o > SMAX)      smp_o = SMAX[OUT_W-1:0];
        else if (sum_o < SMIN) smp_o = SMIN[OUT_W-1:0];
        else                   smp_o = sum_o[OUT_W-1:0];
    end
endmodule

// File: rtl/adpcm_block_decoder.sv
module adpcm_block_decoder
    import adpcm_pkg::*;
#(
    parameter int HIST_W = 32,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blk_start,
    input  logic [BLK_W-1:0]        blk_word,
    input  logic                    byte_valid,
    input  logic [BYTE_W-1:0]       byte_data,
    output logic                    smp_valid,
    output logic signed [OUT_W-1:0] smp_data,
    output logic [IDX_W-1:0]        smp_index,
    output logic                    blk_done,
    output logic                    busy
);
    localparam int HDR_LO = HDR_BYTES * BYTE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SMP_PER_BLK - 1);

    typedef struct packed {
        logic                     busy;
        logic [IDX_W-1:0]         idx;
        logic [SHIFT_W-1:0]       shift;
        logic [SEL_W-1:0]         sel;
        logic [DATA_W-1:0]        data;
        logic signed [HIST_W-1:0] h1;
        logic signed [HIST_W-1:0] h2;
        logic                     vld;
        logic [IDX_W-1:0]         oidx;
        logic signed [OUT_W-1:0]  out;
        logic                     done;
    } dec_t;

    dec_t st_d, st_q;

    logic                     take_byte, gath_full, go;
    logic [BLK_W-1:0]         gath_word, load_w;
    logic [NIB_W-1:0]         cur_nib;
    logic signed [HIST_W-1:0] pred_sum;
    logic signed [OUT_W-1:0]  pred_smp;
    logic                     unused_hdr;

    assign take_byte  = byte_valid && !blk_start && !st_q.busy;
    assign load_w     = blk_start ? blk_word : gath_word;
    assign go         = !st_q.busy && (blk_start || gath_full);
    assign unused_hdr = ^load_w[HDR_LO-1:SHIFT_W+SEL_W];

    adpcm_byte_gather u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take_byte),
        .byte_in (byte_data),
        .full_o  (gath_full),
        .word_o  (gath_word)
    );

    adpcm_nibble_pick u_pick (
        .data_i (st_q.data),
        .idx_i  (st_q.idx),
        .nib_o  (cur_nib)
    );

    adpcm_predictor #(.HIST_W(HIST_W), .OUT_W(OUT_W)) u_pred (
        .nib_i   (cur_nib),
        .shift_i (st_q.shift),
        .sel_i   (st_q.sel),
        .h1_i    (st_q.h1),
        .h2_i    (st_q.h2),
        .sum_o   (pred_sum),
        .smp_o   (pred_smp)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.done = 1'b0;
        if (go) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.shift = load_w[SHIFT_W-1:0];
            st_d.sel   = load_w[SHIFT_W +: SEL_W];
            st_d.data  = load_w[BLK_W-1:HDR_LO];
        end else if (st_q.busy) begin
            st_d.vld  = 1'b1;
            st_d.out  = pred_smp;
            st_d.oidx = st_q.idx;
            st_d.h2   = st_q.h1;
            st_d.h1   = pred_sum;
            st_d.idx  = st_q.idx + IDX_W'(1);
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_valid = st_q.vld;
    assign smp_data  = st_q.out;
    assign smp_index = st_q.oidx;
    assign blk_done  = st_q.done;
    assign busy      = st_q.busy;
endmodule

module adpcm_block_decoder_chk
    import adpcm_pkg::*;
#(
    parameter int HIST_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    blk_start,
    input logic                    smp_valid,
    input logic [IDX_W-1:0]        smp_index,
    input logic                    blk_done,
    input logic                    busy,
    input logic signed [HIST_W-1:0] h1,
    input logic signed [HIST_W-1:0] h2
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SMP_PER_BLK - 1);

    assert_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (smp_valid && smp_index == LAST && !busy));

    assert_index_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_index != LAST) |=>
            (smp_valid && smp_index == IDX_W'($past(smp_index) + 1'b1)));

    assert_first_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_valid) |-> smp_index == '0);

    assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && blk_start) |=> busy);

    assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(h1) && $stable(h2)));

    assert_valid_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(busy));
endmodule

bind adpcm_block_decoder adpcm_block_decoder_chk #(.HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .smp_valid (smp_valid),
    .smp_index (smp_index),
    .blk_done  (blk_done),
    .busy      (busy),
    .h1        (st_q.h1),
    .h2        (st_q.h2)
);

// File: tb/adpcm_block_decoder_test.sv
module adpcm_block_decoder_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_start = 1'b0;
    logic [127:0] blk_word = '0;
    logic         byte_valid = 1'b0;
    logic [7:0]   byte_data = '0;
    logic         smp_valid;
    logic signed [15:0] smp_data;
    logic [4:0]   smp_index;
    logic         blk_done;
    logic         busy;

    int n_chk = 0;
    int n_fail = 0;
    int mh1 = 0;
    int mh2 = 0;
    int exp_q [28];

    always #5 clk = ~clk;

    adpcm_block_decoder uut (
        .clk, .rst_n, .blk_start, .blk_word, .byte_valid, .byte_data,
        .smp_valid, .smp_data, .smp_index, .blk_done, .busy
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input int sh, input int sel, input int seed);
        logic [127:0] w;
        w[3:0]  = 4'(sh);
        w[6:4]  = 3'(sel);
        w[7]    = seed[0];
        w[15:8] = 8'(seed * 37 + 11);
        for (int i = 0; i < 28; i++) w[16 + 4*i +: 4] = 4'(seed * 7 + i * 5 + (i >> 2));
        return w;
    endfunction

    // Independent model of the sample equation; updates the bench history.
    task automatic model_block(input logic [127:0] w);
        int sh, sel, p, n, base, acc, s;
        logic signed [15:0] top;
        sh  = int'(w[3:0]);
        sel = int'(w[6:4]);
        case (sel)
            1: begin p = 60;  n = 0;   end
            2: begin p = 115; n = -52; end
            3: begin p = 98;  n = -55; end
            4: begin p = 122; n = -60; end
            default: begin p = 0; n = 0; end
        endcase
        for (int i = 0; i < 28; i++) begin
            top  = {w[16 + 4*i +: 4], 12'h000};
            base = int'(top);
            base = base >>> sh;
            acc  = mh1 * p + mh2 * n + 32;
            s    = base + acc / 64;
            exp_q[i] = (s > 32767) ? 32767 : ((s < -32768) ? -32768 : s);
            mh2 = mh1;
            mh1 = s;
        end
    endtask

    // Called right after edge S; checks 28 samples and the end of busy.
    task automatic collect(input string tag);
        @(negedge clk);
        chk({tag, " busy after accept (R9)"}, int'(busy), 1);
        for (int i = 0; i < 28; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk({tag, " valid (R1)"}, int'(smp_valid), 1);
            chk({tag, " index (R1)"}, int'(smp_index), i);
            chk({tag, " sample"}, int'(smp_data), exp_q[i]);
            chk({tag, " done (R9)"}, int'(blk_done), (i == 27) ? 1 : 0);
        end
        chk({tag, " busy clear (R9)"}, int'(busy), 0);
    endtask

    task automatic run_par(input logic [127:0] w, input string tag);
        model_block(w);
        @(negedge clk);
        blk_start = 1'b1;
        blk_word  = w;
        @(posedge clk);
        fork
            collect(tag);
            begin @(negedge clk); blk_start = 1'b0; end
        join
    endtask

    task automatic run_bytes(input logic [127:0] w, input bit gaps, input string tag);
        model_block(w);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = w[8*k +: 8];
            @(posedge clk);
            if (gaps && k < 15 && (k % 3) == 1) begin
                @(negedge clk);
                byte_valid = 1'b0;
                @(posedge clk);
            end
        end
        fork
            collect(tag);
            begin @(negedge clk); byte_valid = 1'b0; end
        join
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mh1 = 0;
        mh2 = 0;
    endtask

    task automatic test_reset();
        do_reset();
        @(negedge clk);
        chk("R11 busy", int'(busy), 0);
        chk("R11 valid", int'(smp_valid), 0);
        chk("R11 done", int'(blk_done), 0);
    endtask

    task automatic test_header();
        logic [127:0] w;
        // R3 R4: shift in bits 3:0, bit 7 and flag byte vary, selector 0
        w = mk(4, 0, 3);
        run_par(w, "R3 R4 shift4");
        w = mk(0, 0, 6);
        run_par(w, "R3 R4 shift0");
        w = mk(15, 0, 9);
        run_par(w, "R3 shift15");
    endtask

    task automatic test_filters();
        // R5 R8: each selector, history carried from block to block
        for (int s = 1; s <= 4; s++) run_par(mk(9, s, s + 20), "R5 R8 selector");
        for (int s = 5; s <= 7; s++) run_par(mk(10, s, s + 40), "R5 selector fallback");
    endtask

    task automatic test_trunc();
        logic [127:0] w;
        do_reset();
        // R6: sample0 = -1, sample1 = (-60+32)/64 -> 0, not -1
        w = '0;
        w[3:0] = 4'd12;
        w[6:4] = 3'd1;
        w[19:16] = 4'hF;
        run_par(w, "R6 R8 trunc");
        chk("R6 model sample1", exp_q[1], 0);
    endtask

    task automatic test_clamp();
        logic [127:0] w;
        do_reset();
        w = '0;
        w[6:4] = 3'd4;
        for (int i = 0; i < 28; i++) w[16 + 4*i +: 4] = 4'h7;
        run_par(w, "R7 clamp high");
        chk("R7 model saturates", exp_q[1], 32767);
        for (int i = 0; i < 28; i++) w[16 + 4*i +: 4] = 4'h8;
        run_par(w, "R7 clamp low");
    endtask

    task automatic test_bytes();
        run_bytes(mk(6, 3, 55), 1'b1, "R2 bytes gaps");
        run_bytes(mk(3, 2, 56), 1'b0, "R2 bytes");
    endtask

    task automatic test_busy_ignore();
        logic [127:0] w;
        w = mk(5, 2, 70);
        model_block(w);
        @(negedge clk);
        blk_start = 1'b1;
        blk_word  = w;
        @(posedge clk);
        fork
            collect("R9 busy ignore");
            begin
                @(negedge clk);
                blk_word = mk(1, 1, 99);
                for (int k = 0; k < 20; k++) begin
                    blk_start  = k[0];
                    byte_valid = 1'b1;
                    byte_data  = 8'(k * 13);
                    @(negedge clk);
                end
                blk_start  = 1'b0;
                byte_valid = 1'b0;
            end
        join
        @(posedge clk);
        @(negedge clk);
        chk("R9 no restart valid", int'(smp_valid), 0);
        chk("R9 no restart busy", int'(busy), 0);
        run_bytes(mk(7, 4, 71), 1'b0, "R9 byte count untouched");
    endtask

    task automatic test_priority();
        logic [127:0] w;
        w = mk(8, 1, 80);
        model_block(w);
        @(negedge clk);
        blk_start  = 1'b1;
        blk_word   = w;
        byte_valid = 1'b1;
        byte_data  = 8'hAB;
        @(posedge clk);
        fork
            collect("R10 strobe wins");
            begin @(negedge clk); blk_start = 1'b0; byte_valid = 1'b0; end
        join
        run_bytes(mk(2, 3, 81), 1'b0, "R10 byte not taken");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_header();
        test_filters();
        test_trunc();
        test_clamp();
        test_bytes();
        test_busy_ignore();
        test_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule